// File: doc/BRIEF.md
# Packet Radio Receive Controller with Frame Buffer Lock

This block is the digital sequencing logic for the receive side of a low-rate packet radio. A host issues transceiver commands that move a small state register between off, synthesizer-ready and two receive states. While the controller sits in a receive state, it waits for a sync-header detection pulse from the demodulator. It accepts the pulse only when the current signal strength reaches a host-programmed threshold.

Once a frame has been accepted, the controller writes the incoming bytes through a single write port into a 128-byte frame buffer. The length byte goes first, then the payload, then a link quality byte. It signals the start and the end of the frame with one-cycle interrupt pulses, and each pulse is mirrored in a sticky status bit that the host clears by writing a 1.

Two host bits keep the buffer from being overwritten. The dynamic bit locks the buffer after a frame that ends with a good checksum, until the host clears the bit. The static bit stops all sync detection while it is set. In both cases the controller stays in its receive state.

Top module: `rx_frame_ctrl`

## Requirements
- R1: After reset the state output is 0 (off), both interrupt pulses and both sticky bits are 0, and no buffer write is issued.
- R2: The state codes are off=0, ready=1, basic receive=2 and extended receive=3. The command codes are 1 (off), 2 (ready), 3 (receive) and 4 (receive with auto-acknowledge). Command 3 moves the state to 2 on the next clock, but only from state 0 or 1.
- R3: Command 4 moves the state to 3 on the next clock, only from state 0 or 1.
- R4: These commands are ignored and leave the state unchanged: a receive command given in a receive state, unknown codes, and any command to leave a receive state while a frame is in progress.
- R5: A sync pulse is accepted only when the RSSI value is greater than or equal to the threshold. A rejected pulse raises no interrupt and causes no buffer write.
- R6: An accepted sync pulse raises the start pulse for exactly one cycle, on the clock after the pulse, and sets the start sticky bit.
- R7: The byte after an accepted sync is the length L. It is written to address 0, and payload byte k (1..L) is written to address k. Each write appears on the port one clock after its byte is presented.
- R8: One clock after the last payload byte (or after the length byte when L=0), the link quality byte is written to address L+1. In the same cycle the end pulse is high for one cycle and the end sticky bit is set.
- R9: A length byte above 126 is still written to address 0. The frame is then dropped: no further writes, no end pulse, and the next sync pulse can be accepted.
- R10: A sticky bit is cleared by a 1 on its clear input. A new pulse in the same cycle wins over the clear.
- R11: With the dynamic protection bit set, a frame ending with a good checksum locks the buffer. Sync pulses are refused and commands to leave the receive state are ignored until the bit is cleared, which releases the lock on the next clock.
- R12: A frame ending with a bad checksum does not lock the buffer, even with the dynamic bit set.
- R13: While the static protection bit is set, no sync pulse is accepted and commands to leave the receive state are ignored. Detection resumes once the bit is cleared.
- R14: The lock decision is taken only at frame end. If the dynamic bit is cleared while a frame is in progress, that frame completes normally and does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code |
| dynProtEn | input | 1 | Dynamic buffer protection enable |
| staticProtEn | input | 1 | Static protection (sync detection off) |
| rssiThresh | input | 5 | Detection threshold |
| rssiVal | input | 5 | Current RSSI value |
| shrDet | input | 1 | Sync header detected pulse |
| byteValid | input | 1 | Demodulated byte strobe |
| byteData | input | 8 | Demodulated byte |
| lqiVal | input | 8 | Link quality value for the current frame |
| fcsOk | input | 1 | Checksum good, sampled at frame end |
| clrStart | input | 1 | Write-1 clear of the start sticky bit |
| clrEnd | input | 1 | Write-1 clear of the end sticky bit |
| trxState | output | 2 | Current transceiver state code |
| irqStart | output | 1 | Frame start pulse |
| irqEnd | output | 1 | Frame end pulse |
| stickyStart | output | 1 | Start sticky status |
| stickyEnd | output | 1 | End sticky status |
| fbWe | output | 1 | Frame buffer write enable |
| fbAddr | output | 7 | Frame buffer write address |
| fbData | output | 8 | Frame buffer write data |

## Verification
A wrong frame phase or a wrong byte pointer shows within one clock of the next demodulated byte, as a missing, extra or misaddressed buffer write. A lock flag that is wrongly set or wrongly cleared shows on the very next sync pulse, as a start pulse that is missing or unexpected. A wrong state register shows on the state output one clock after the command. The directed scenarios therefore check every write, pulse and state code in the exact cycle it is due, including the zero-length frame, the oversized length, and changes to the protection bits made in the middle of a frame.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;
  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_READY    = 2'd1,
    ST_RX_BASIC = 2'd2,
    ST_RX_EXT   = 2'd3
  } trxState_t;

  localparam logic [2:0] CMD_OFF    = 3'd1;
  localparam logic [2:0] CMD_READY  = 3'd2;
  localparam logic [2:0] CMD_RX     = 3'd3;
  localparam logic [2:0] CMD_RX_ACK = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEN  = 2'd1,
    PH_PAY  = 2'd2,
    PH_LQI  = 2'd3
  } phase_t;

  typedef struct packed {
    logic wrLen;
    logic wrPay;
    logic wrLqi;
  } pathStrobe_t;
endpackage

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
  import rx_frame_pkg::*;
#(
  parameter int RSSI_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic              dynProtEn,
  input  logic              staticProtEn,
  input  logic [RSSI_W-1:0] rssiThresh,
  input  logic [RSSI_W-1:0] rssiVal,
  input  logic              shrDet,
  input  logic              byteValid,
  input  logic              fcsOk,
  input  logic              clrStart,
  input  logic              clrEnd,
  input  logic              lenBad,
  input  logic              lenZero,
  input  logic              lastPay,
  output pathStrobe_t       strobe,
  output logic [1:0]        trxCode,
  output logic              irqStart,
  output logic              irqEnd,
  output logic              stickyStart,
  output logic              stickyEnd
);
  trxState_t trxReg, trxNext;
  phase_t    phase, phaseNext;
  logic      dynLock;
  logic      inRx, frameBusy, holdRx, rssiOk, accept;

  assign inRx      = (trxReg == ST_RX_BASIC) || (trxReg == ST_RX_EXT);
  assign frameBusy = (phase != PH_IDLE);
  assign holdRx    = inRx && (frameBusy || dynLock || staticProtEn);
  assign rssiOk    = (rssiVal >= rssiThresh);
  assign accept    = inRx && !frameBusy && shrDet && rssiOk && !staticProtEn && !dynLock;
  assign trxCode   = trxReg;

  // transceiver state commands
  always_comb begin
    trxNext = trxReg;
    if (cmdValid) begin
      case (cmdCode)
        CMD_OFF:    if (!holdRx) trxNext = ST_OFF;
        CMD_READY:  if (!holdRx) trxNext = ST_READY;
        CMD_RX:     if (!inRx)   trxNext = ST_RX_BASIC;
        CMD_RX_ACK: if (!inRx)   trxNext = ST_RX_EXT;
        default:    trxNext = trxReg;
      endcase
    end
  end

  // frame phase sequencing
  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE: if (accept) phaseNext = PH_LEN;
      PH_LEN: begin
        if (byteValid) begin
          if (lenBad)       phaseNext = PH_IDLE;
          else if (lenZero) phaseNext = PH_LQI;
          else              phaseNext = PH_PAY;
        end
      end
      PH_PAY:  if (byteValid && lastPay) phaseNext = PH_LQI;
      PH_LQI:  phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strobe.wrLen = (phase == PH_LEN) && byteValid;
    strobe.wrPay = (phase == PH_PAY) && byteValid;
    strobe.wrLqi = (phase == PH_LQI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trxReg      <= ST_OFF;
      phase       <= PH_IDLE;
      dynLock     <= 1'b0;
      irqStart    <= 1'b0;
      irqEnd      <= 1'b0;
      stickyStart <= 1'b0;
      stickyEnd   <= 1'b0;
    end else begin
      trxReg      <= trxNext;
      phase       <= phaseNext;
      irqStart    <= accept;
      irqEnd      <= (phase == PH_LQI);
      stickyStart <= accept | (stickyStart & ~clrStart);
      stickyEnd   <= (phase == PH_LQI) | (stickyEnd & ~clrEnd);
      // lock decided at frame end only; released when host drops the bit
      if (phase == PH_LQI)  dynLock <= dynProtEn && fcsOk;
      else if (!dynProtEn)  dynLock <= 1'b0;
    end
  end

  a_r2_rx_basic_entry: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_RX && (trxReg == ST_OFF || trxReg == ST_READY))
      |=> (trxReg == ST_RX_BASIC));

  a_r3_rx_ext_entry: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_RX_ACK && (trxReg == ST_OFF || trxReg == ST_READY))
      |=> (trxReg == ST_RX_EXT));

  a_r4_hold_in_rx: assert property (@(posedge clk) disable iff (!rstN)
    (holdRx && cmdValid) |=> (trxReg == $past(trxReg)));

  a_r5_rssi_gate: assert property (@(posedge clk) disable iff (!rstN)
    (shrDet && (rssiVal < rssiThresh)) |=> !irqStart);

  a_r6_start_single: assert property (@(posedge clk) disable iff (!rstN)
    irqStart |=> !irqStart);

  a_r11_lock_refuses: assert property (@(posedge clk) disable iff (!rstN)
    dynLock |=> !irqStart);

  a_r13_static_gate: assert property (@(posedge clk) disable iff (!rstN)
    staticProtEn |=> !irqStart);
endmodule

// File: rtl/rx_frame_path.sv
module rx_frame_path
  import rx_frame_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int MAX_LEN = 126
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic [DATA_W-1:0] byteData,
  input  logic [DATA_W-1:0] lqiVal,
  output logic              lenBad,
  output logic              lenZero,
  output logic              lastPay,
  output logic              fbWe,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [DATA_W-1:0] fbData
);
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] remaining;

  assign lenBad  = (byteData > DATA_W'(MAX_LEN));
  assign lenZero = (byteData == '0);
  assign lastPay = (remaining == ADDR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbWe      <= 1'b0;
      fbAddr    <= '0;
      fbData    <= '0;
      ptr       <= '0;
      remaining <= '0;
    end else begin
      fbWe <= strobe.wrLen | strobe.wrPay | strobe.wrLqi;
      if (strobe.wrLen) begin
        fbAddr    <= '0;
        fbData    <= byteData;
        ptr       <= ADDR_W'(1);
        remaining <= byteData[ADDR_W-1:0];
      end else if (strobe.wrPay) begin
        fbAddr    <= ptr;
        fbData    <= byteData;
        ptr       <= ptr + ADDR_W'(1);
        remaining <= remaining - ADDR_W'(1);
      end else if (strobe.wrLqi) begin
        fbAddr <= ptr;
        fbData <= lqiVal;
      end
    end
  end

  a_r7_payload_within_length: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPay |-> (remaining != '0));
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_frame_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int RSSI_W = 5,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int MAX_LEN = DEPTH - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic              dynProtEn,
  input  logic              staticProtEn,
  input  logic [RSSI_W-1:0] rssiThresh,
  input  logic [RSSI_W-1:0] rssiVal,
  input  logic              shrDet,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic [DATA_W-1:0] lqiVal,
  input  logic              fcsOk,
  input  logic              clrStart,
  input  logic              clrEnd,
  output logic [1:0]        trxState,
  output logic              irqStart,
  output logic              irqEnd,
  output logic              stickyStart,
  output logic              stickyEnd,
  output logic              fbWe,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [DATA_W-1:0] fbData
);
  pathStrobe_t strobe;
  logic lenBad, lenZero, lastPay;

  rx_frame_seq #(.RSSI_W(RSSI_W)) i_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .dynProtEn(dynProtEn), .staticProtEn(staticProtEn),
    .rssiThresh(rssiThresh), .rssiVal(rssiVal), .shrDet(shrDet),
    .byteValid(byteValid), .fcsOk(fcsOk), .clrStart(clrStart), .clrEnd(clrEnd),
    .lenBad(lenBad), .lenZero(lenZero), .lastPay(lastPay), .strobe(strobe),
    .trxCode(trxState), .irqStart(irqStart), .irqEnd(irqEnd),
    .stickyStart(stickyStart), .stickyEnd(stickyEnd)
  );

  rx_frame_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData), .lqiVal(lqiVal),
    .lenBad(lenBad), .lenZero(lenZero), .lastPay(lastPay),
    .fbWe(fbWe), .fbAddr(fbAddr), .fbData(fbData)
  );
endmodule

// File: tb/test_rx_frame_ctrl.sv
`timescale 1ns/1ps
module test_rx_frame_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = '0;
  logic       dynProtEn = 1'b0, staticProtEn = 1'b0;
  logic [4:0] rssiThresh = 5'd10, rssiVal = 5'd20;
  logic       shrDet = 1'b0, byteValid = 1'b0, fcsOk = 1'b0;
  logic [7:0] byteData = '0, lqiVal = '0;
  logic       clrStart = 1'b0, clrEnd = 1'b0;
  logic [1:0] trxState;
  logic       irqStart, irqEnd, stickyStart, stickyEnd, fbWe;
  logic [6:0] fbAddr;
  logic [7:0] fbData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  rx_frame_ctrl i_rx_frame_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .dynProtEn(dynProtEn), .staticProtEn(staticProtEn), .rssiThresh(rssiThresh),
    .rssiVal(rssiVal), .shrDet(shrDet), .byteValid(byteValid), .byteData(byteData),
    .lqiVal(lqiVal), .fcsOk(fcsOk), .clrStart(clrStart), .clrEnd(clrEnd),
    .trxState(trxState), .irqStart(irqStart), .irqEnd(irqEnd),
    .stickyStart(stickyStart), .stickyEnd(stickyEnd),
    .fbWe(fbWe), .fbAddr(fbAddr), .fbData(fbData)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [2:0] code, input int expState, input string req);
    cmdValid = 1'b1; cmdCode = code;
    step();
    cmdValid = 1'b0;
    chk(req, "state", trxState, expState);
  endtask

  // sync pulse expected to be refused: no start pulse, next byte not written
  task automatic refuseFrame(input string req);
    shrDet = 1'b1;
    step();
    shrDet = 1'b0;
    chk(req, "start pulse on refused sync", irqStart, 0);
    byteValid = 1'b1; byteData = 8'd2;
    step();
    byteValid = 1'b0;
    chk(req, "write after refused sync", fbWe, 0);
  endtask

  // full accepted frame with cycle-exact port checks
  task automatic goodFrame(input int len, input logic [7:0] lqi, input logic fcs,
                           input string req, input bit dropDynMid);
    shrDet = 1'b1;
    step();
    shrDet = 1'b0;
    chk(req, "start pulse", irqStart, 1);
    chk(req, "start sticky", stickyStart, 1);
    byteValid = 1'b1; byteData = 8'(len);
    step();
    byteValid = 1'b0;
    chk(req, "start pulse width", irqStart, 0);
    chk(req, "len write", fbWe, 1);
    chk(req, "len addr", fbAddr, 0);
    chk(req, "len data", fbData, len);
    if (dropDynMid) dynProtEn = 1'b0;
    for (int k = 1; k <= len; k++) begin
      byteValid = 1'b1; byteData = 8'(8'h30 + k);
      step();
      byteValid = 1'b0;
      chk(req, "payload addr", fbAddr, k);
      chk(req, "payload data", fbData, 8'h30 + k);
      chk(req, "end not early", irqEnd, 0);
    end
    lqiVal = lqi; fcsOk = fcs;
    step();
    fcsOk = 1'b0;
    chk("R8", "lqi write", fbWe, 1);
    chk("R8", "lqi addr", fbAddr, len + 1);
    chk("R8", "lqi data", fbData, lqi);
    chk("R8", "end pulse", irqEnd, 1);
    chk("R8", "end sticky", stickyEnd, 1);
    step();
    chk("R8", "end pulse width", irqEnd, 0);
    chk("R8", "no extra write", fbWe, 0);
  endtask

  initial begin
    step();
    chk("R1", "reset state", trxState, 0);
    chk("R1", "reset start pulse", irqStart, 0);
    chk("R1", "reset end pulse", irqEnd, 0);
    chk("R1", "reset sticky", stickyStart + stickyEnd, 0);
    chk("R1", "reset write", fbWe, 0);
    rstN = 1'b1;
    step();

    // state commands
    sendCmd(3'd4, 3, "R3");
    sendCmd(3'd3, 3, "R4 rx in rx");
    sendCmd(3'd2, 1, "R4 leave rx when idle");
    sendCmd(3'd7, 1, "R4 unknown code");
    sendCmd(3'd3, 2, "R2");
    sendCmd(3'd4, 2, "R4 ack rx in rx");

    // RSSI gate
    rssiVal = 5'd9;
    refuseFrame("R5 below threshold");
    rssiVal = 5'd10;
    goodFrame(3, 8'hA5, 1'b1, "R6 R7 at threshold", 1'b0);

    // sticky clear
    clrStart = 1'b1;
    step();
    clrStart = 1'b0;
    chk("R10", "start sticky cleared", stickyStart, 0);
    chk("R10", "end sticky kept", stickyEnd, 1);
    clrEnd = 1'b1;
    step();
    clrEnd = 1'b0;
    chk("R10", "end sticky cleared", stickyEnd, 0);

    // zero length
    goodFrame(0, 8'h5C, 1'b1, "R8 zero length", 1'b0);

    // set wins over clear
    clrStart = 1'b1; shrDet = 1'b1;
    step();
    clrStart = 1'b0; shrDet = 1'b0;
    chk("R10", "set wins over clear", stickyStart, 1);
    // finish that frame: length 1
    byteValid = 1'b1; byteData = 8'd1; step();
    byteData = 8'h77; step();
    byteValid = 1'b0; step();
    chk("R8", "lqi addr len1", fbAddr, 2);
    step();

    // oversized length dropped
    shrDet = 1'b1; step(); shrDet = 1'b0;
    chk("R9", "start pulse", irqStart, 1);
    byteValid = 1'b1; byteData = 8'd127; step();
    chk("R9", "len written", fbWe, 1);
    chk("R9", "len addr", fbAddr, 0);
    byteData = 8'h11; step();
    byteValid = 1'b0;
    chk("R9", "no payload write", fbWe, 0);
    step();
    chk("R9", "no end pulse", irqEnd, 0);
    chk("R9", "no write later", fbWe, 0);
    goodFrame(1, 8'h21, 1'b0, "R9 next accepted", 1'b0);

    // command during frame ignored
    shrDet = 1'b1; step(); shrDet = 1'b0;
    sendCmd(3'd1, 2, "R4 leave during frame");
    byteValid = 1'b1; byteData = 8'd0; step();
    byteValid = 1'b0; step();
    chk("R4", "frame completed", irqEnd, 1);
    step();

    // dynamic protection
    dynProtEn = 1'b1;
    goodFrame(2, 8'h40, 1'b0, "R12 bad fcs", 1'b0);
    goodFrame(2, 8'h41, 1'b1, "R12 overwrite after bad fcs", 1'b0);
    refuseFrame("R11 locked");
    sendCmd(3'd1, 2, "R11 stay in rx");
    dynProtEn = 1'b0;
    step();
    goodFrame(1, 8'h42, 1'b1, "R11 released", 1'b0);

    // clearing the bit mid-frame
    dynProtEn = 1'b1;
    goodFrame(2, 8'h43, 1'b1, "R14 mid-frame clear", 1'b1);
    goodFrame(1, 8'h44, 1'b1, "R14 no lock", 1'b0);

    // static protection
    staticProtEn = 1'b1;
    refuseFrame("R13 static");
    sendCmd(3'd2, 2, "R13 stay in rx");
    staticProtEn = 1'b0;
    goodFrame(1, 8'h45, 1'b0, "R13 resumed", 1'b0);
    sendCmd(3'd1, 0, "R2 off from rx");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule